// File: doc/BRIEF.md
# VID Reference Stepper

This block keeps a digital reference code in step with a voltage-identification (VID) request. The VID code comes from outside the clock domain. It passes through a two-flop synchronizer. A slot timer then splits every switching period into six evenly spaced sample slots, and the code is examined at each slot. When a sample differs from the current DAC code, the block waits half a switching period (three slots) to confirm the request. If the pending difference changes during that wait, the wait restarts from the sample that saw the new difference. If the difference disappears, the request is dropped and nothing changes.

Once the request is confirmed, the DAC code moves by one LSB (one 6.25 mV reference step) toward the requested code. It keeps moving by one LSB at every sample slot until the two codes match. A large jump therefore slews at six LSB per switching period. Each change to the DAC code comes with a one-clock step strobe. During the synchronous reset, the DAC code is loaded directly from the synchronized VID code, with no stepping.

Top module: `vid_ref_stepper`

## Requirements
- R1: While `rst` is high, `dacCode` takes the synchronized `vidCode` directly, no later than three clocks after `vidCode` settles, and `stepStrobe` stays low. After release, `dacCode` equals `vidCode` and does not move until a change is requested.
- R2: The synchronized VID code is sampled once every PERIOD_CLKS/6 clocks, which gives six evenly spaced slots per switching period. A high `cycleMark` restarts the slot timer, and the next sample falls one slot later.
- R3: The first step after a change is taken no earlier than three slots (half a period) after the sample that detects the change. With the defaults (60-clock period), the first strobe falls 33 to 42 clocks after `vidCode` changes.
- R4: Every change of `dacCode` is exactly +1 or -1 LSB, always toward the synchronized VID code. Upward steps and downward steps are both supported.
- R5: If the difference between VID and DAC codes changes to another nonzero value during the wait, no step is taken. The wait restarts from the sample that saw the new difference, so the first strobe falls 33 to 42 clocks after the second change.
- R6: If the VID code returns to the DAC code during the wait, no step is taken at all.
- R7: After the first step, each further step follows exactly one slot later (10 clocks with the defaults, six per period). Stepping stops on the step that makes the codes equal.
- R8: `dacCode` is registered. It changes only in the clock in which `stepStrobe` is high, and `stepStrobe` is high for exactly one clock per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the DAC code from the VID code |
| cycleMark | input | 1 | One-clock mark of the switching-cycle start; realigns the slot timer |
| vidCode | input | CODE_W | Requested VID code, asynchronous to `clk` |
| dacCode | output | CODE_W | Current registered DAC reference code |
| stepStrobe | output | 1 | High for one clock with each one-LSB change of `dacCode` |

## Verification
The bench measures how long it takes, from each VID change, until the first step strobe. A hold counter that is stuck or off by one shows up at the ports within one slot, as a first step outside the 33 to 42 clock window. A pending-difference register that is not refreshed, or not compared, shows up as a step after a cancelled or reverted request. A wrong direction or step size in the datapath shows up in the code of the very first strobe. A slot timer that runs too fast or too slow shows up as a spacing between consecutive steps that is not exactly one slot.

// File: rtl/vid_step_pkg.sv
package vid_step_pkg;

  // Command word from the control to the datapath, one clock wide.
  typedef struct packed {
    logic load;   // copy synchronized VID into the DAC register
    logic step;   // move the DAC register by one LSB
    logic up;     // step direction: 1 = increment
  } stepCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_SLEW = 2'd2
  } ctrlState_e;

endpackage

// File: rtl/vid_step_timer.sv
module vid_step_timer #(
  parameter int SLOT_CLKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic cycleMark,
  output logic slotTick
);

  generate
    if (SLOT_CLKS <= 1) begin : gSingle
      // every clock is a sample slot
      assign slotTick = 1'b1;
    end else begin : gCount
      localparam int CW = $clog2(SLOT_CLKS);
      localparam logic [CW-1:0] LAST = CW'(SLOT_CLKS - 1);
      logic [CW-1:0] slotCnt;

      assign slotTick = (slotCnt == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          slotCnt <= '0;
        end else if (slotTick || cycleMark) begin
          slotCnt <= '0;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/vid_step_ctrl.sv
module vid_step_ctrl
  import vid_step_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int HOLD_SLOTS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slotTick,
  input  logic signed [CODE_W:0]   codeDiff,
  output stepCmd_t                 cmd
);

  localparam int DW = CODE_W + 1;
  localparam int HW = (HOLD_SLOTS > 1) ? $clog2(HOLD_SLOTS) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_SLOTS - 1);
  localparam logic signed [DW-1:0] DIFF_PLUS  = DW'(1);
  localparam logic signed [DW-1:0] DIFF_MINUS = {DW{1'b1}};

  ctrlState_e             state, stateNxt;
  logic signed [DW-1:0]   pendDiff, pendNxt;
  logic [HW-1:0]          holdCnt, holdNxt;
  logic                   diffZero, diffUnit, towardUp;

  assign diffZero = (codeDiff == '0);
  assign diffUnit = (codeDiff == DIFF_PLUS) || (codeDiff == DIFF_MINUS);
  assign towardUp = ~codeDiff[DW-1];

  always_comb begin
    stateNxt = state;
    pendNxt  = pendDiff;
    holdNxt  = holdCnt;
    cmd      = '0;
    cmd.load = rst;
    cmd.up   = towardUp;
    if (!rst && slotTick) begin
      unique case (state)
        ST_IDLE: begin
          if (!diffZero) begin
            stateNxt = ST_HOLD;
            pendNxt  = codeDiff;
            holdNxt  = '0;
          end
        end
        ST_HOLD: begin
          if (diffZero) begin
            stateNxt = ST_IDLE;
          end else if (codeDiff != pendDiff) begin
            // difference moved: restart confirmation from this sample
            pendNxt = codeDiff;
            holdNxt = '0;
          end else if (holdCnt == HOLD_LAST) begin
            cmd.step = 1'b1;
            stateNxt = diffUnit ? ST_IDLE : ST_SLEW;
          end else begin
            holdNxt = holdCnt + 1'b1;
          end
        end
        ST_SLEW: begin
          if (diffZero) begin
            stateNxt = ST_IDLE;
          end else begin
            cmd.step = 1'b1;
            if (diffUnit) stateNxt = ST_IDLE;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pendDiff <= '0;
      holdCnt  <= '0;
    end else begin
      state    <= stateNxt;
      pendDiff <= pendNxt;
      holdCnt  <= holdNxt;
    end
  end

endmodule

// File: rtl/vid_step_dp.sv
module vid_step_dp
  import vid_step_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                   clk,
  input  stepCmd_t               cmd,
  input  logic [CODE_W-1:0]      vidRaw,
  output logic [CODE_W-1:0]      vidSync,
  output logic [CODE_W-1:0]      dacReg,
  output logic                   stepPulse,
  output logic signed [CODE_W:0] codeDiff
);

  logic [CODE_W-1:0] vidMeta;

  // two-stage synchronizer, no reset needed
  always_ff @(posedge clk) begin
    vidMeta <= vidRaw;
    vidSync <= vidMeta;
  end

  assign codeDiff = $signed({1'b0, vidSync}) - $signed({1'b0, dacReg});

  always_ff @(posedge clk) begin
    if (cmd.load) begin
      dacReg <= vidSync;
    end else if (cmd.step) begin
      dacReg <= cmd.up ? dacReg + 1'b1 : dacReg - 1'b1;
    end
    stepPulse <= cmd.step & ~cmd.load;
  end

endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper
  import vid_step_pkg::*;
#(
  parameter int CODE_W           = 8,
  parameter int PERIOD_CLKS      = 60,
  parameter int SLOTS_PER_PERIOD = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycleMark,
  input  logic [CODE_W-1:0] vidCode,
  output logic [CODE_W-1:0] dacCode,
  output logic              stepStrobe
);

  localparam int SLOT_CLKS  = PERIOD_CLKS / SLOTS_PER_PERIOD;
  localparam int HOLD_SLOTS = SLOTS_PER_PERIOD / 2;

  stepCmd_t                cmd;
  logic                    slotTick;
  logic [CODE_W-1:0]       vidSync;
  logic signed [CODE_W:0]  codeDiff;

  vid_step_timer #(.SLOT_CLKS(SLOT_CLKS)) timerInst (
    .clk      (clk),
    .rst      (rst),
    .cycleMark(cycleMark),
    .slotTick (slotTick)
  );

  vid_step_ctrl #(.CODE_W(CODE_W), .HOLD_SLOTS(HOLD_SLOTS)) ctrlInst (
    .clk     (clk),
    .rst     (rst),
    .slotTick(slotTick),
    .codeDiff(codeDiff),
    .cmd     (cmd)
  );

  vid_step_dp #(.CODE_W(CODE_W)) dpInst (
    .clk      (clk),
    .cmd      (cmd),
    .vidRaw   (vidCode),
    .vidSync  (vidSync),
    .dacReg   (dacCode),
    .stepPulse(stepStrobe),
    .codeDiff (codeDiff)
  );

endmodule

// File: rtl/vid_step_chk.sv
module vid_step_chk #(
  parameter int CODE_W    = 8,
  parameter int SLOT_CLKS = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dacCode,
  input logic              stepStrobe,
  input logic [CODE_W-1:0] vidSync
);

  localparam int CW = $clog2(SLOT_CLKS + 1);
  localparam logic [CW-1:0] GAP_FULL = CW'(SLOT_CLKS);

  // clocks since the last strobe, saturating at one slot
  logic [CW-1:0] sinceStep;
  always_ff @(posedge clk) begin
    if (rst) sinceStep <= GAP_FULL;
    else if (stepStrobe) sinceStep <= CW'(1);
    else if (sinceStep != GAP_FULL) sinceStep <= sinceStep + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !stepStrobe);

  // R4
  step_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (stepStrobe && !$past(rst)) |->
      (($past(vidSync) > $past(dacCode)) ? (dacCode == $past(dacCode) + 1'b1)
                                         : (dacCode == $past(dacCode) - 1'b1)));

  // R8
  no_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (!stepStrobe && !$past(rst)) |-> $stable(dacCode));

  // R7
  slot_gap_chk: assert property (@(posedge clk) disable iff (rst)
    stepStrobe |-> (sinceStep == GAP_FULL));

endmodule

bind vid_ref_stepper vid_step_chk #(.CODE_W(CODE_W), .SLOT_CLKS(SLOT_CLKS)) chkInst (
  .clk       (clk),
  .rst       (rst),
  .dacCode   (dacCode),
  .stepStrobe(stepStrobe),
  .vidSync   (vidSync)
);

// File: tb/vid_ref_stepper_test.sv
module vid_ref_stepper_test;

  localparam int CODE_W      = 8;
  localparam int PERIOD_CLKS = 60;
  localparam int SLOT_CLKS   = 10;
  localparam int FIRST_MIN   = 33;
  localparam int FIRST_MAX   = 42;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cycleMark = 1'b0;
  logic [CODE_W-1:0] vidCode = 8'h40;
  logic [CODE_W-1:0] dacCode;
  logic              stepStrobe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int driveCyc = 0;
  int lastStepCyc = 0;
  bit firstPending = 0;
  bit silentChange = 0;
  bit done = 0;
  logic [CODE_W-1:0] lastDac;
  logic [CODE_W-1:0] modelDac;
  logic [CODE_W-1:0] expItem;
  logic [CODE_W-1:0] expQ[$];

  vid_ref_stepper #(.CODE_W(CODE_W), .PERIOD_CLKS(PERIOD_CLKS)) uut (
    .clk       (clk),
    .rst       (rst),
    .cycleMark (cycleMark),
    .vidCode   (vidCode),
    .dacCode   (dacCode),
    .stepStrobe(stepStrobe)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // cycle-start mark, aligned with the free-running slot grid
  initial forever begin
    @(negedge clk);
    cycleMark = !rst && (((cyc + 1) % PERIOD_CLKS) == 0);
  end

  // monitor: pops expected codes on every strobe
  always @(negedge clk) begin
    if (rst) begin
      lastDac = dacCode;
    end else if (!done) begin
      if (stepStrobe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5/R6", "unexpected step", int'(dacCode), int'(lastDac));
        end else begin
          expItem = expQ.pop_front();
          check(dacCode == expItem, "R4", "step code", int'(dacCode), int'(expItem));
          if (firstPending) begin
            check((cyc - driveCyc >= FIRST_MIN) && (cyc - driveCyc <= FIRST_MAX),
                  "R3/R5", "first step delay", cyc - driveCyc, FIRST_MIN);
            firstPending = 0;
          end else begin
            check(cyc - lastStepCyc == SLOT_CLKS, "R2/R7", "step spacing",
                  cyc - lastStepCyc, SLOT_CLKS);
          end
        end
        lastStepCyc = cyc;
      end else if (dacCode !== lastDac) begin
        silentChange = 1;
      end
      lastDac = dacCode;
    end
  end

  task automatic doReset(input logic [CODE_W-1:0] v);
    @(negedge clk);
    rst = 1'b1;
    vidCode = v;
    repeat (5) @(negedge clk);
    check(dacCode == v, "R1", "load in reset", int'(dacCode), int'(v));
    check(stepStrobe == 1'b0, "R1", "strobe in reset", int'(stepStrobe), 0);
    expQ.delete();
    modelDac = v;
    firstPending = 0;
    silentChange = 0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(dacCode == v, "R1", "code after release", int'(dacCode), int'(v));
  endtask

  // driver: applies a VID code and pushes the expected step codes
  task automatic applyVid(input logic [CODE_W-1:0] v, input bit expectSteps);
    @(negedge clk);
    vidCode = v;
    driveCyc = cyc;
    firstPending = expectSteps;
    if (expectSteps) begin
      while (modelDac != v) begin
        modelDac = (v > modelDac) ? modelDac + 1'b1 : modelDac - 1'b1;
        expQ.push_back(modelDac);
      end
    end
  endtask

  task automatic endScenario(input string name);
    for (int i = 0; i < 2000 && expQ.size() != 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R7", {name, " steps left"}, expQ.size(), 0);
    check(dacCode == modelDac, "R4", {name, " final code"}, int'(dacCode), int'(modelDac));
    check(!silentChange, "R8", {name, " change without strobe"}, int'(silentChange), 0);
    silentChange = 0;
  endtask

  initial begin
    modelDac = 8'h40;
    doReset(8'h40);
    repeat (20) @(negedge clk);
    check(stepStrobe == 1'b0 && dacCode == 8'h40, "R1", "idle after reset",
          int'(dacCode), 8'h40);

    applyVid(8'h41, 1'b1);           // one LSB up (R3)
    endScenario("up1");
    applyVid(8'h40, 1'b1);           // one LSB down (R4)
    endScenario("down1");
    applyVid(8'h4C, 1'b1);           // large jump up, slews (R7)
    endScenario("up12");
    applyVid(8'h45, 1'b1);           // large jump down (R4, R7)
    endScenario("down7");

    // R5: difference moves during the wait, hold restarts
    applyVid(8'h46, 1'b0);
    repeat (15) @(negedge clk);
    applyVid(8'h47, 1'b1);
    endScenario("restart");

    // R6: request withdrawn during the wait, nothing happens
    applyVid(8'h48, 1'b0);
    repeat (15) @(negedge clk);
    applyVid(8'h47, 1'b0);
    repeat (80) @(negedge clk);
    endScenario("withdraw");

    // R1: reset mid-run loads directly, then a downward slew
    doReset(8'h90);
    applyVid(8'h8E, 1'b1);
    endScenario("afterReset");

    // boundary: slew down to zero
    doReset(8'h03);
    applyVid(8'h00, 1'b1);
    endScenario("toZero");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule